// File: doc/BRIEF.md
# Load Queue with Ordering-Violation Search

This block keeps the loads of an out-of-order core in program order inside a circular queue. Each slot holds the load's sequence number, its address line (the effective address shifted right by `GRAN_BITS`, which by default gives 256-byte granules), a flag telling whether that address has been computed yet, and a reference into the store queue. The reference is captured when the load is allocated. The ring has one more physical slot than its usable capacity, so the full and empty cases can be told apart. Retirement removes loads from the oldest end. A squash cuts loads away from the youngest end.

When a store computes its address, it probes the queue. It supplies its address line and the load-queue tail position that was captured when the store itself was allocated. The queue scans from that position toward the current tail. The first load found with a computed address in the same line is reported as a memory-ordering violator.

A small state machine owns that report:
- `VIO_IDLE` moves to `VIO_REPORT` when a probe hits.
- `VIO_REPORT` lasts one cycle and raises the pulse. It then moves to `VIO_HOLD`, or goes straight back to `VIO_IDLE` if `vio_clear` is already high.
- `VIO_HOLD` keeps the violator visible until `vio_clear` returns the machine to `VIO_IDLE`.

Probes are ignored in every state except `VIO_IDLE`.

Top module: `ldq_order_queue`

## Requirements
- R1: After reset the queue is empty: `lq_count` is 0, `alloc_idx` is 0, `alloc_ready` is 1, and `vio_pending` and `vio_pulse` are 0.
- R2: The ring has CAP+1 slots. An accepted allocation writes the slot shown on `alloc_idx` and advances it, wrapping from CAP to 0. `alloc_ready` is low while `lq_count` equals CAP.
- R3: An allocated load records `{1'b0, alloc_sq_tail}` as its store reference, or all ones (-1) when `alloc_sq_empty` is high. A violation reports this value on `vio_sq_ref`.
- R4: A commit retires loads from the oldest end, in order, for as long as each one's sequence number is at most `commit_seq`. It stops at the first load that is younger.
- R5: A squash removes loads from the youngest end for as long as each one's sequence number exceeds `squash_seq`. The tail moves back once per removed load and wraps from 0 to CAP.
- R6: A squash in the same cycle as a commit wins, and that commit is dropped. `alloc_ready` is low in any cycle where `squash_valid` is high.
- R7: A probe matches a load only when the load's address has been computed and its address line equals `probe_line`. A newly allocated load has no address.
- R8: The scan covers the slots from `probe_lq_idx` up to, but not including, the tail, oldest first. The first match wins. Slots before `probe_lq_idx` are never reported.
- R9: In the cycle after a hit, `vio_pulse` is high for exactly one cycle. At the same time `vio_idx` shows the violator's slot and `vio_seq` its sequence number.
- R10: While `vio_pending` is high, probes are ignored and the reported violator stays unchanged. `vio_clear` drops `vio_pending` on the next edge.
- R11: A probe sees the queue as it stood before the same cycle's allocation and address writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate a load |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_empty | input | 1 | Store queue is empty at allocation |
| alloc_sq_tail | input | SQ_IDX_W | Store-queue tail at allocation |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_idx | output | IDX_W | Slot given to the next allocation (the tail) |
| addr_valid | input | 1 | A load's address is being written |
| addr_idx | input | IDX_W | Slot of that load |
| addr_line | input | LINE_W | Effective address shifted right by GRAN_BITS |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| probe_valid | input | 1 | Store address probe |
| probe_line | input | LINE_W | Store address line |
| probe_lq_idx | input | IDX_W | Load tail captured when the store was allocated |
| vio_clear | input | 1 | Consume the reported violator |
| vio_pulse | output | 1 | One-cycle violation pulse |
| vio_pending | output | 1 | A reported violator has not been consumed |
| vio_idx | output | IDX_W | Violator slot |
| vio_seq | output | SEQ_W | Violator sequence number |
| vio_sq_ref | output | SQ_IDX_W+1 | Violator's store reference |
| lq_count | output | CNT_W | Loads in the queue |

## Verification
The hardest situation to reach is a probe whose scan window wraps around the end of the ring. It must start after a matching older load, and it must land on a line match in a slot that has just been reused. Getting there requires fill, commit, squash and refill in a particular order. Directed steps first fill the queue, then commit part of it, squash past the commit in the same cycle, and refill across the wrap point. Each probe is placed so that a match lies before `probe_lq_idx` and is skipped. A long random phase then draws address lines from only four values, so hits, misses, held reports and reused slots occur often. Every cycle is compared with a bench model of the ring.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    typedef enum logic [1:0] {
        VIO_IDLE   = 2'd0,
        VIO_REPORT = 2'd1,
        VIO_HOLD   = 2'd2
    } vio_state_e;

    // Ring arithmetic on slot positions of a ring with `depth` slots.
    function automatic int ring_fwd(input int base, input int off, input int depth);
        int s;
        s = base + off;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

    function automatic int ring_back(input int base, input int off, input int depth);
        int s;
        s = base - off;
        if (s < 0) s = s + depth;
        return s;
    endfunction

endpackage

// File: rtl/ldq_retire_calc.sv
module ldq_retire_calc #(
    parameter int DEPTH = 9,
    parameter int CAP   = 8,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 4
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [IDX_W-1:0]            tail,
    input  logic [CNT_W-1:0]            count,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_arr,
    input  logic [SEQ_W-1:0]            commit_seq,
    input  logic [SEQ_W-1:0]            squash_seq,
    output logic [CNT_W-1:0]            n_commit,
    output logic [CNT_W-1:0]            n_squash
);
    import ldq_pkg::*;

    // Oldest-first walk: count leading entries old enough to retire.
    always_comb begin
        logic             run;
        logic [IDX_W-1:0] idx;
        run      = 1'b1;
        n_commit = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = IDX_W'(ring_fwd(int'(head), i, DEPTH));
            if (run && (i < int'(count)) && (seq_arr[idx] <= commit_seq))
                n_commit = n_commit + CNT_W'(1);
            else
                run = 1'b0;
        end
    end

    // Youngest-first walk: count trailing entries younger than the squash point.
    always_comb begin
        logic             run;
        logic [IDX_W-1:0] idx;
        run      = 1'b1;
        n_squash = '0;
        for (int j = 1; j <= DEPTH; j++) begin
            idx = IDX_W'(ring_back(int'(tail), j, DEPTH));
            if (run && (j <= int'(count)) && (seq_arr[idx] > squash_seq))
                n_squash = n_squash + CNT_W'(1);
            else
                run = 1'b0;
        end
    end

endmodule

// File: rtl/ldq_probe_scan.sv
module ldq_probe_scan #(
    parameter int DEPTH  = 9,
    parameter int IDX_W  = 4,
    parameter int LINE_W = 24
) (
    input  logic [IDX_W-1:0]             tail,
    input  logic [IDX_W-1:0]             start_idx,
    input  logic [LINE_W-1:0]            probe_line,
    input  logic [DEPTH-1:0][LINE_W-1:0] line_arr,
    input  logic [DEPTH-1:0]             line_ok,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    import ldq_pkg::*;

    always_comb begin
        int               span;
        logic [IDX_W-1:0] idx;
        span    = ring_back(int'(tail), int'(start_idx), DEPTH);
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = IDX_W'(ring_fwd(int'(start_idx), i, DEPTH));
            if (!hit && (i < span) && line_ok[idx] && (line_arr[idx] == probe_line)) begin
                hit     = 1'b1;
                hit_idx = idx;
            end
        end
    end

endmodule

// File: rtl/ldq_vio_fsm.sv
module ldq_vio_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic probe_valid,
    input  logic hit,
    input  logic vio_clear,
    output logic capture,
    output logic vio_pulse,
    output logic vio_pending
);
    import ldq_pkg::*;

    vio_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VIO_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIO_IDLE:   if (probe_valid && hit) state_d = VIO_REPORT;
            VIO_REPORT: state_d = vio_clear ? VIO_IDLE : VIO_HOLD;
            VIO_HOLD:   if (vio_clear) state_d = VIO_IDLE;
            default:    state_d = VIO_IDLE;
        endcase
    end

    always_comb begin
        capture     = (state_q == VIO_IDLE) && probe_valid && hit;
        vio_pulse   = (state_q == VIO_REPORT);
        vio_pending = (state_q != VIO_IDLE);
    end

endmodule

// File: rtl/ldq_order_queue.sv
module ldq_order_queue #(
    parameter int CAP       = 8,
    parameter int SEQ_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 8,
    parameter int SQ_IDX_W  = 4,
    localparam int DEPTH    = CAP + 1,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(CAP + 1),
    localparam int LINE_W   = ADDR_W - GRAN_BITS,
    localparam int SQREF_W  = SQ_IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic                alloc_sq_empty,
    input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
    output logic                alloc_ready,
    output logic [IDX_W-1:0]    alloc_idx,
    input  logic                addr_valid,
    input  logic [IDX_W-1:0]    addr_idx,
    input  logic [LINE_W-1:0]   addr_line,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    input  logic                probe_valid,
    input  logic [LINE_W-1:0]   probe_line,
    input  logic [IDX_W-1:0]    probe_lq_idx,
    input  logic                vio_clear,
    output logic                vio_pulse,
    output logic                vio_pending,
    output logic [IDX_W-1:0]    vio_idx,
    output logic [SEQ_W-1:0]    vio_seq,
    output logic [SQREF_W-1:0]  vio_sq_ref,
    output logic [CNT_W-1:0]    lq_count
);
    import ldq_pkg::*;

    logic [IDX_W-1:0]              head_q, tail_q;
    logic [CNT_W-1:0]              count_q;
    logic [DEPTH-1:0][SEQ_W-1:0]   seq_q;
    logic [DEPTH-1:0][LINE_W-1:0]  line_q;
    logic [DEPTH-1:0]              line_ok_q;
    logic [DEPTH-1:0][SQREF_W-1:0] sqref_q;

    logic             full, alloc_fire, do_commit;
    logic [CNT_W-1:0] n_commit, n_squash;
    logic             hit, capture;
    logic [IDX_W-1:0] hit_idx;
    logic [SQREF_W-1:0] new_sqref;

    assign full        = (count_q == CNT_W'(CAP));
    assign alloc_ready = !full && !squash_valid;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign do_commit   = commit_valid && !squash_valid;
    assign alloc_idx   = tail_q;
    assign lq_count    = count_q;
    assign new_sqref   = alloc_sq_empty ? {SQREF_W{1'b1}} : {1'b0, alloc_sq_tail};

    ldq_retire_calc #(
        .DEPTH(DEPTH), .CAP(CAP), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_retire (
        .head(head_q), .tail(tail_q), .count(count_q), .seq_arr(seq_q),
        .commit_seq(commit_seq), .squash_seq(squash_seq),
        .n_commit(n_commit), .n_squash(n_squash)
    );

    ldq_probe_scan #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_W(LINE_W)
    ) u_scan (
        .tail(tail_q), .start_idx(probe_lq_idx), .probe_line(probe_line),
        .line_arr(line_q), .line_ok(line_ok_q), .hit(hit), .hit_idx(hit_idx)
    );

    ldq_vio_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .hit(hit),
        .vio_clear(vio_clear), .capture(capture),
        .vio_pulse(vio_pulse), .vio_pending(vio_pending)
    );

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (squash_valid) begin
            tail_q  <= IDX_W'(ring_back(int'(tail_q), int'(n_squash), DEPTH));
            count_q <= count_q - n_squash;
        end else begin
            if (do_commit)
                head_q <= IDX_W'(ring_fwd(int'(head_q), int'(n_commit), DEPTH));
            if (alloc_fire)
                tail_q <= IDX_W'(ring_fwd(int'(tail_q), 1, DEPTH));
            count_q <= count_q - (do_commit ? n_commit : CNT_W'(0))
                               + CNT_W'(alloc_fire);
        end
    end

    // Per-slot storage.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seq_q[g]     <= '0;
                line_q[g]    <= '0;
                line_ok_q[g] <= 1'b0;
                sqref_q[g]   <= '0;
            end else begin
                if (alloc_fire && (tail_q == IDX_W'(g))) begin
                    seq_q[g]     <= alloc_seq;
                    sqref_q[g]   <= new_sqref;
                    line_ok_q[g] <= 1'b0;
                end
                if (addr_valid && (addr_idx == IDX_W'(g))) begin
                    line_q[g]    <= addr_line;
                    line_ok_q[g] <= 1'b1;
                end
            end
        end
    end

    // Violator record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vio_idx    <= '0;
            vio_seq    <= '0;
            vio_sq_ref <= '0;
        end else if (capture) begin
            vio_idx    <= hit_idx;
            vio_seq    <= seq_q[hit_idx];
            vio_sq_ref <= sqref_q[hit_idx];
        end
    end

endmodule

// File: rtl/ldq_order_queue_chk.sv
module ldq_order_queue_chk #(
    parameter int CAP   = 8,
    parameter int CNT_W = 4,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             commit_valid,
    input logic             squash_valid,
    input logic             vio_pulse,
    input logic             vio_pending,
    input logic [IDX_W-1:0] vio_idx
);

    assert_occupancy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(CAP));

    assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(CAP)) |-> !alloc_ready);

    assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !commit_valid) |=> (count == $past(count) + CNT_W'(1)));

    assert_squash_blocks_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !alloc_ready);

    assert_squash_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (count <= $past(count)));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vio_pulse |=> !vio_pulse);

    assert_pulse_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vio_pulse |-> vio_pending);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vio_pending && !vio_pulse) |-> $stable(vio_idx));

endmodule

bind ldq_order_queue ldq_order_queue_chk #(
    .CAP(CAP), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count_q),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .commit_valid(commit_valid), .squash_valid(squash_valid),
    .vio_pulse(vio_pulse), .vio_pending(vio_pending), .vio_idx(vio_idx)
);

// File: tb/ldq_order_queue_bench.sv
module ldq_order_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CAP    = 8;
    localparam int DEPTH  = CAP + 1;
    localparam int SEQ_W  = 16;
    localparam int ADDR_W = 32;
    localparam int GRAN   = 8;
    localparam int SQW    = 4;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 4;
    localparam int LINE_W = ADDR_W - GRAN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid, alloc_sq_empty, alloc_ready;
    logic [SEQ_W-1:0] alloc_seq, commit_seq, squash_seq, vio_seq;
    logic [SQW-1:0] alloc_sq_tail;
    logic [IDX_W-1:0] alloc_idx, addr_idx, probe_lq_idx, vio_idx;
    logic addr_valid, commit_valid, squash_valid, probe_valid, vio_clear;
    logic [LINE_W-1:0] addr_line, probe_line;
    logic vio_pulse, vio_pending;
    logic [SQW:0] vio_sq_ref;
    logic [CNT_W-1:0] lq_count;

    ldq_order_queue u_ldq_order_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_sq_empty(alloc_sq_empty),
        .alloc_sq_tail(alloc_sq_tail), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_line(addr_line),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .probe_valid(probe_valid), .probe_line(probe_line), .probe_lq_idx(probe_lq_idx),
        .vio_clear(vio_clear), .vio_pulse(vio_pulse), .vio_pending(vio_pending),
        .vio_idx(vio_idx), .vio_seq(vio_seq), .vio_sq_ref(vio_sq_ref), .lq_count(lq_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Bench model of the ring.
    int m_seq [DEPTH];
    int m_line[DEPTH];
    bit m_ok  [DEPTH];
    int m_sq  [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    int m_vst = 0;   // 0 idle, 1 report, 2 hold
    int m_vidx = 0, m_vseq = 0, m_vsq = 0;
    int next_seq = 1;

    function automatic int winc(int i); return (i + 1) % DEPTH; endfunction
    function automatic int wdec(int i); return (i + DEPTH - 1) % DEPTH; endfunction
    function automatic int line_of(int addr); return addr >>> GRAN; endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_seq = '0; alloc_sq_empty = 0; alloc_sq_tail = '0;
        addr_valid = 0; addr_idx = '0; addr_line = '0;
        commit_valid = 0; commit_seq = '0; squash_valid = 0; squash_seq = '0;
        probe_valid = 0; probe_line = '0; probe_lq_idx = '0; vio_clear = 0;
    endtask

    task automatic set_alloc(bit sq_empty, int sq_tail);
        alloc_valid = 1; alloc_seq = SEQ_W'(next_seq);
        alloc_sq_empty = sq_empty; alloc_sq_tail = SQW'(sq_tail);
    endtask

    // Called at a falling edge with inputs driven; advances one clock.
    task automatic run_cycle();
        bit exp_ready, hit;
        int hi, i;
        #1;
        exp_ready = (m_cnt != CAP) && !squash_valid;
        chk("R2 R6 alloc_ready", int'(alloc_ready), int'(exp_ready));
        hit = 0; hi = 0;
        if (probe_valid && m_vst == 0) begin
            i = int'(probe_lq_idx);
            while (i != m_tail && !hit) begin
                if (m_ok[i] && m_line[i] == int'(probe_line)) begin hit = 1; hi = i; end
                i = winc(i);
            end
        end
        if (hit) begin m_vidx = hi; m_vseq = m_seq[hi]; m_vsq = m_sq[hi]; end
        case (m_vst)
            0: if (hit) m_vst = 1;
            1: m_vst = vio_clear ? 0 : 2;
            default: if (vio_clear) m_vst = 0;
        endcase
        if (addr_valid) begin m_line[addr_idx] = int'(addr_line); m_ok[addr_idx] = 1; end
        if (squash_valid) begin
            while (m_cnt > 0 && m_seq[wdec(m_tail)] > int'(squash_seq)) begin
                m_tail = wdec(m_tail); m_cnt--;
            end
        end else begin
            if (commit_valid)
                while (m_cnt > 0 && m_seq[m_head] <= int'(commit_seq)) begin
                    m_head = winc(m_head); m_cnt--;
                end
            if (alloc_valid && exp_ready) begin
                m_seq[m_tail] = int'(alloc_seq);
                m_sq[m_tail]  = alloc_sq_empty ? 31 : int'(alloc_sq_tail);
                m_ok[m_tail]  = 0;
                m_tail = winc(m_tail); m_cnt++;
                next_seq++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2 R4 R5 lq_count", int'(lq_count), m_cnt);
        chk("R2 R5 alloc_idx", int'(alloc_idx), m_tail);
        chk("R10 vio_pending", int'(vio_pending), int'(m_vst != 0));
        chk("R9 vio_pulse", int'(vio_pulse), int'(m_vst == 1));
        if (m_vst != 0) begin
            chk("R8 vio_idx", int'(vio_idx), m_vidx);
            chk("R9 vio_seq", int'(vio_seq), m_vseq);
            chk("R3 vio_sq_ref", int'(vio_sq_ref), m_vsq);
        end
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < DEPTH; k++) begin m_seq[k] = 0; m_line[k] = 0; m_ok[k] = 0; m_sq[k] = 0; end
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 count", int'(lq_count), 0);
        chk("R1 alloc_idx", int'(alloc_idx), 0);
        chk("R1 ready", int'(alloc_ready), 1);
        chk("R1 pending", int'(vio_pending), 0);
        chk("R1 pulse", int'(vio_pulse), 0);

        // Fill: slots 0..7 get seqs 1..8.
        for (int k = 0; k < CAP; k++) begin set_alloc(k == 0, k); run_cycle(); end
        chk("R2 full count", int'(lq_count), 8);
        chk("R2 full ready", int'(alloc_ready), 0);
        set_alloc(0, 0); run_cycle();
        chk("R2 refused", int'(lq_count), 8);

        addr_valid = 1; addr_idx = 2; addr_line = LINE_W'(line_of(32'h1234)); run_cycle();
        addr_valid = 1; addr_idx = 5; addr_line = LINE_W'(line_of(32'h12FF)); run_cycle();
        addr_valid = 1; addr_idx = 6; addr_line = LINE_W'(line_of(32'h1300)); run_cycle();

        probe_valid = 1; probe_lq_idx = 3; probe_line = LINE_W'(line_of(32'h1200)); run_cycle();
        chk("R8 first match after start", int'(vio_idx), 5);
        chk("R9 violator seq", int'(vio_seq), 6);
        chk("R9 pulse", int'(vio_pulse), 1);

        probe_valid = 1; probe_lq_idx = 0; probe_line = LINE_W'(line_of(32'h1234)); run_cycle();
        chk("R10 ignored while pending", int'(vio_idx), 5);
        vio_clear = 1; run_cycle();
        chk("R10 cleared", int'(vio_pending), 0);

        probe_valid = 1; probe_lq_idx = 0; probe_line = LINE_W'(line_of(32'h1400)); run_cycle();
        chk("R7 no line match", int'(vio_pending), 0);
        probe_valid = 1; probe_lq_idx = 3; probe_line = LINE_W'(line_of(32'h0000)); run_cycle();
        chk("R7 unaddressed never match", int'(vio_pending), 0);

        addr_valid = 1; addr_idx = 7; addr_line = LINE_W'(line_of(32'h5000));
        probe_valid = 1; probe_lq_idx = 7; probe_line = LINE_W'(line_of(32'h5000)); run_cycle();
        chk("R11 same-cycle write unseen", int'(vio_pending), 0);
        probe_valid = 1; probe_lq_idx = 7; probe_line = LINE_W'(line_of(32'h5000)); run_cycle();
        chk("R11 seen next cycle", int'(vio_idx), 7);
        vio_clear = 1; run_cycle();

        commit_valid = 1; commit_seq = 3; run_cycle();
        chk("R4 partial commit", int'(lq_count), 5);
        commit_valid = 1; commit_seq = 2; run_cycle();
        chk("R4 nothing old enough", int'(lq_count), 5);

        squash_valid = 1; squash_seq = 6; commit_valid = 1; commit_seq = 8; run_cycle();
        chk("R6 squash wins", int'(lq_count), 3);
        chk("R5 tail back", int'(alloc_idx), 6);

        for (int k = 0; k < 5; k++) begin set_alloc(0, k + 1); run_cycle(); end
        chk("R2 wrapped tail", int'(alloc_idx), 2);
        chk("R2 full after wrap", int'(alloc_ready), 0);

        squash_valid = 1; squash_seq = 10; run_cycle();
        chk("R5 squash across wrap", int'(alloc_idx), 8);
        chk("R5 squash count", int'(lq_count), 5);

        set_alloc(1, 0); run_cycle();
        addr_valid = 1; addr_idx = 8; addr_line = LINE_W'(line_of(32'h7700)); run_cycle();
        probe_valid = 1; probe_lq_idx = 8; probe_line = LINE_W'(line_of(32'h77AB)); run_cycle();
        chk("R3 empty store marker", int'(vio_sq_ref), 31);
        chk("R8 wrapped window", int'(vio_idx), 8);
        vio_clear = 1; run_cycle();

        // Random phase.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 100 < 50) set_alloc(($urandom % 4) == 0, int'($urandom % 16));
            if (m_cnt > 0 && $urandom % 100 < 40) begin
                addr_valid = 1;
                addr_idx   = IDX_W'((m_head + int'($urandom % m_cnt)) % DEPTH);
                addr_line  = LINE_W'($urandom % 4);
            end
            if (m_cnt > 0 && $urandom % 100 < 15) begin
                int c;
                c = m_seq[m_head] + int'($urandom % 3) - 1;
                if (c < 0) c = 0;
                commit_valid = 1; commit_seq = SEQ_W'(c);
            end
            if (m_cnt > 0 && $urandom % 100 < 5) begin
                int s;
                s = m_seq[wdec(m_tail)] - int'($urandom % 4);
                if (s < 0) s = 0;
                squash_valid = 1; squash_seq = SEQ_W'(s);
            end
            if ($urandom % 100 < 30) begin
                probe_valid  = 1;
                probe_lq_idx = IDX_W'((m_head + int'($urandom % (m_cnt + 1))) % DEPTH);
                probe_line   = LINE_W'($urandom % 4);
            end
            if ($urandom % 100 < 30) vio_clear = 1;
            run_cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule